// File: doc/BRIEF.md
# Indexed Bus Register Accessor

This block is a host-side master for an external 16-bit indexed register bus. That bus exposes two ports. A write to the command port selects a register and the bytes of interest. A later access to the data port moves the register contents. The block takes a single request over a valid/ready handshake. Each request names a register offset, an access size (one byte or one 16-bit word), a direction and write data. The block turns it into a command cycle followed by a data cycle.

The block builds the command word from the offset. Byte-enable flags, derived from the low offset bits, go in the top nibble and the offset goes in the low bits. During the data cycle the block steers the byte to or from the correct half of the 16-bit data word. Byte accesses work whatever the device's native width is, so they are the ones to use when first probing a device's configuration. After the data cycle ends, a one-cycle response pulse returns the read data.

Top module: `idxbus_master`

## Requirements
- R1: While reset is held and on the first cycle after it, req_ready is 1, bus_cs_n, bus_rd_n and bus_wr_n are 1, and rsp_valid is 0.
- R2: During the command phase the block drives port address 2 with bus_wr_n low and bus_rd_n high. The command word carries byte-enable flags in bits 15..12 (bit 12 is byte 0, up to bit 15 for byte 3) and the 12-bit register offset in bits 11..0.
- R3: For a byte access the enable nibble is 4'b0001 shifted left by offset bits 1..0.
- R4: For a word access the enable nibble is 4'b0011 shifted left by twice offset bit 1.
- R5: A byte read returns data bits 15..8 when offset bit 0 is 1 and bits 7..0 when it is 0, zero-extended to 16 bits. A word read returns all 16 bits.
- R6: The data phase uses port address 0. A byte write drives req_wdata[7:0] onto the lane selected by offset bit 0 (1 means bits 15..8) with the other lane 0. A word write drives req_wdata unchanged.
- R7: The command phase holds bus_cs_n low for STROBE_CYC clocks. Exactly one clock with bus_cs_n high follows, then the data phase holds bus_cs_n low for STROBE_CYC clocks. bus_rd_n and bus_wr_n are never low together.
- R8: req_ready is 1 only while no access is in progress. A request held valid during an access is not accepted and starts no bus cycle.
- R9: rsp_valid pulses for exactly one clock after each data phase. rsp_rdata carries the read result for reads and 0 for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken on this edge |
| req_ofs | input | OFS_W | Register offset |
| req_wide | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data (low byte used for byte writes) |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read result, zero for writes |
| bus_addr | output | 2 | Port select: 2 command, 0 data |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_dout | output | 16 | Data driven onto the bus |
| bus_dout_en | output | 1 | High while bus_dout must be driven |
| bus_din | input | 16 | Data returned by the bus |

## Verification
Byte reads are issued at all four offset alignments against a data word whose two halves differ (0xA55A). Each read must produce a distinct enable bit and the correct half, which exposes any wrong shift or swapped lane. Word reads at both halfword alignments separate the 0x3 from the 0xC enable pattern. Byte writes on both lanes use write data with a non-zero upper byte, which shows whether the unused lane is forced to zero. A request held valid across a whole access shows whether a busy block wrongly starts a second command.

// File: rtl/idxbus_pkg.sv
// Shared constants and types for the indexed bus accessor.
package idxbus_pkg;
    localparam int unsigned BUS_W  = 16;
    localparam int unsigned BE_W   = 4;
    localparam int unsigned IDX_W  = BUS_W - BE_W;
    localparam logic [1:0]  PORT_DATA = 2'd0;
    localparam logic [1:0]  PORT_CMD  = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_GAP,
        ST_DATA,
        ST_RESP
    } seq_state_e;
endpackage

// File: rtl/idxbus_cmd_enc.sv
// Command word encoder.
// Builds {byte enables, offset} from the offset and access size.
// Assumes OFS_W is between 2 and IDX_W so the offset never reaches the enable nibble.
module idxbus_cmd_enc
    import idxbus_pkg::*;
#(
    parameter int unsigned OFS_W = 12
) (
    input  logic [OFS_W-1:0] ofs,
    input  logic             wide,
    output logic [BUS_W-1:0] cmd
);
    logic [BE_W-1:0] be;

    // Enable nibble: one byte flag or an aligned pair, shifted by the low offset bits.
    always_comb begin
        if (wide) be = 4'b0011 << {ofs[1], 1'b0};
        else      be = 4'b0001 << ofs[1:0];
    end

    // Pad the offset into the low field of the word.
    generate
        if (OFS_W < IDX_W) begin : g_pad
            assign cmd = {be, {(IDX_W-OFS_W){1'b0}}, ofs};
        end else begin : g_full
            assign cmd = {be, ofs[IDX_W-1:0]};
        end
    endgenerate
endmodule

// File: rtl/idxbus_lane.sv
// Byte lane steering between the request side and the 16-bit data word.
// Assumes byte accesses select their lane with offset bit 0 only.
module idxbus_lane
    import idxbus_pkg::*;
(
    input  logic             ofs0,
    input  logic             wide,
    input  logic [BUS_W-1:0] wdata,
    input  logic [BUS_W-1:0] rword,
    output logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] rdata
);
    localparam int unsigned HALF = BUS_W / 2;

    // Outbound: place the byte on its lane and zero the other lane.
    always_comb begin
        if (wide)      bus_wdata = wdata;
        else if (ofs0) bus_wdata = {wdata[HALF-1:0], {HALF{1'b0}}};
        else           bus_wdata = {{HALF{1'b0}}, wdata[HALF-1:0]};
    end

    // Inbound: pick the addressed half and zero-extend it.
    always_comb begin
        if (wide)      rdata = rword;
        else if (ofs0) rdata = {{HALF{1'b0}}, rword[BUS_W-1:HALF]};
        else           rdata = {{HALF{1'b0}}, rword[HALF-1:0]};
    end
endmodule

// File: rtl/idxbus_seq.sv
// Access sequencer: command phase, one idle clock, data phase, response.
// Assumes STROBE_CYC >= 1. start is honoured only in the idle state.
module idxbus_seq
    import idxbus_pkg::*;
#(
    parameter int unsigned STROBE_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic idle,
    output logic in_cmd,
    output logic in_data,
    output logic capture,
    output logic rsp
);
    localparam int unsigned CNT_W = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STROBE_CYC - 1);

    seq_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic             last_beat;

    assign last_beat = (cnt == LAST);

    // State and strobe-length counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state <= ST_CMD;
                    cnt   <= '0;
                end
                ST_CMD: if (last_beat) begin
                    state <= ST_GAP;
                    cnt   <= '0;
                end else begin
                    cnt <= cnt + CNT_W'(1);
                end
                ST_GAP: state <= ST_DATA;
                ST_DATA: if (last_beat) begin
                    state <= ST_RESP;
                    cnt   <= '0;
                end else begin
                    cnt <= cnt + CNT_W'(1);
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Phase decode.
    always_comb begin
        idle    = (state == ST_IDLE);
        in_cmd  = (state == ST_CMD);
        in_data = (state == ST_DATA);
        capture = in_data && last_beat;
        rsp     = (state == ST_RESP);
    end
endmodule

// File: rtl/idxbus_master.sv
// Indexed bus register accessor (top).
// Takes one byte or word request, writes the command word to port 2,
// then reads or writes port 0 and pulses rsp_valid.
// Assumes bus_din is valid on the last clock of a read data phase.
module idxbus_master
    import idxbus_pkg::*;
#(
    parameter int unsigned OFS_W      = 12,
    parameter int unsigned STROBE_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [OFS_W-1:0] req_ofs,
    input  logic             req_wide,
    input  logic             req_write,
    input  logic [15:0]      req_wdata,
    output logic             rsp_valid,
    output logic [15:0]      rsp_rdata,
    output logic [1:0]       bus_addr,
    output logic             bus_cs_n,
    output logic             bus_rd_n,
    output logic             bus_wr_n,
    output logic [15:0]      bus_dout,
    output logic             bus_dout_en,
    input  logic [15:0]      bus_din
);
    logic [OFS_W-1:0] ofs_q;
    logic             wide_q;
    logic             write_q;
    logic [BUS_W-1:0] wdata_q;
    logic [BUS_W-1:0] rword_q;
    logic [BUS_W-1:0] cmd_word;
    logic [BUS_W-1:0] lane_wdata;
    logic [BUS_W-1:0] lane_rdata;
    logic             idle, in_cmd, in_data, capture, rsp;
    logic             accept;

    assign req_ready = idle;
    assign accept    = req_valid && idle;

    // Hold the request for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs_q   <= '0;
            wide_q  <= 1'b0;
            write_q <= 1'b0;
            wdata_q <= '0;
        end else if (accept) begin
            ofs_q   <= req_ofs;
            wide_q  <= req_wide;
            write_q <= req_write;
            wdata_q <= req_wdata;
        end
    end

    // Capture the data word at the end of a read data phase.
    always_ff @(posedge clk) begin
        if (!rst_n)                   rword_q <= '0;
        else if (capture && !write_q) rword_q <= bus_din;
    end

    idxbus_seq #(.STROBE_CYC(STROBE_CYC)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (accept),
        .idle    (idle),
        .in_cmd  (in_cmd),
        .in_data (in_data),
        .capture (capture),
        .rsp     (rsp)
    );

    idxbus_cmd_enc #(.OFS_W(OFS_W)) u_enc (
        .ofs  (ofs_q),
        .wide (wide_q),
        .cmd  (cmd_word)
    );

    idxbus_lane u_lane (
        .ofs0      (ofs_q[0]),
        .wide      (wide_q),
        .wdata     (wdata_q),
        .rword     (rword_q),
        .bus_wdata (lane_wdata),
        .rdata     (lane_rdata)
    );

    // Bus pins decoded from the current phase.
    always_comb begin
        bus_cs_n    = !(in_cmd || in_data);
        bus_wr_n    = !(in_cmd || (in_data && write_q));
        bus_rd_n    = !(in_data && !write_q);
        bus_addr    = in_cmd ? PORT_CMD : PORT_DATA;
        bus_dout_en = in_cmd || (in_data && write_q);
        if (in_cmd)                  bus_dout = cmd_word;
        else if (in_data && write_q) bus_dout = lane_wdata;
        else                         bus_dout = '0;
    end

    // Response: read result for reads, zero for writes.
    always_comb begin
        rsp_valid = rsp;
        rsp_rdata = (rsp && !write_q) ? lane_rdata : '0;
    end
endmodule

// File: rtl/idxbus_master_chk.sv
// Protocol checker for idxbus_master, attached by bind.
// Assumes synchronous active-low reset.
module idxbus_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic [1:0]  bus_addr,
    input logic        bus_cs_n,
    input logic        bus_rd_n,
    input logic        bus_wr_n,
    input logic [15:0] bus_dout
);
    a_r1_ready_bus_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (bus_cs_n && bus_rd_n && bus_wr_n));

    a_r7_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && !bus_wr_n));

    a_r2_cmd_is_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && bus_addr == 2'd2) |-> (!bus_wr_n && bus_rd_n));

    a_r2_be_count: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && bus_addr == 2'd2) |->
            ($countones(bus_dout[15:12]) == 1 || $countones(bus_dout[15:12]) == 2));

    a_r7_gap_then_data: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_cs_n) && $past(bus_addr) == 2'd2) |=> (!bus_cs_n && bus_addr == 2'd0));

    a_r9_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r9_rsp_after_data: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid) |-> ($past(!bus_cs_n) && $past(bus_addr) == 2'd0));
endmodule

bind idxbus_master idxbus_master_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .bus_addr  (bus_addr),
    .bus_cs_n  (bus_cs_n),
    .bus_rd_n  (bus_rd_n),
    .bus_wr_n  (bus_wr_n),
    .bus_dout  (bus_dout)
);

// File: tb/tb_idxbus_master.sv
`timescale 1ns/1ps
// Directed bench for idxbus_master. A monitor records each access's phases.
module tb_idxbus_master;
    localparam int unsigned OFS_W      = 12;
    localparam int unsigned STROBE_CYC = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [OFS_W-1:0] req_ofs = '0;
    logic             req_wide = 1'b0;
    logic             req_write = 1'b0;
    logic [15:0]      req_wdata = '0;
    logic             rsp_valid;
    logic [15:0]      rsp_rdata;
    logic [1:0]       bus_addr;
    logic             bus_cs_n, bus_rd_n, bus_wr_n, bus_dout_en;
    logic [15:0]      bus_dout;
    logic [15:0]      dev_word = 16'hA55A;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // Monitor records
    int          m_cmd_len, m_gap, m_data_len, m_rsp_w, m_acc, m_both;
    logic [15:0] m_cmd, m_wdata, m_rdata;
    logic        m_data_rd;

    always #4 clk = ~clk;

    idxbus_master #(.OFS_W(OFS_W), .STROBE_CYC(STROBE_CYC)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_ofs(req_ofs),
        .req_wide(req_wide), .req_write(req_write), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .bus_addr(bus_addr), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
        .bus_wr_n(bus_wr_n), .bus_dout(bus_dout), .bus_dout_en(bus_dout_en),
        .bus_din(dev_word)
    );

    always @(posedge clk) begin
        if (req_valid && req_ready) m_acc++;
    end

    always @(negedge clk) begin
        if (!bus_rd_n && !bus_wr_n) m_both++;
        if (!bus_cs_n && bus_addr == 2'd2) begin
            m_cmd_len++;
            if (!bus_wr_n) m_cmd = bus_dout;
        end
        if (!bus_cs_n && bus_addr == 2'd0) begin
            m_data_len++;
            m_data_rd = !bus_rd_n;
            if (!bus_wr_n) m_wdata = bus_dout;
        end
        if (bus_cs_n && m_cmd_len > 0 && m_data_len == 0) m_gap++;
        if (rsp_valid) begin
            m_rsp_w++;
            m_rdata = rsp_rdata;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=%0d cycles expected=<100000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_acc(input logic [OFS_W-1:0] ofs, input logic wide, input logic wr,
                          input logic [15:0] wd, input int hold);
        @(negedge clk);
        m_cmd_len = 0; m_gap = 0; m_data_len = 0; m_rsp_w = 0; m_acc = 0; m_both = 0;
        m_cmd = '0; m_wdata = '0; m_rdata = 16'hDEAD; m_data_rd = 1'b0;
        req_ofs = ofs; req_wide = wide; req_write = wr; req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        repeat (hold) @(negedge clk);
        req_valid = 1'b0;
        for (int t = 0; t < 50 && !rsp_valid; t++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 ready", 32'(req_ready), 32'd1);
        chk("R1 strobes", {29'd0, bus_cs_n, bus_rd_n, bus_wr_n}, 32'h7);
        chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    endtask

    task automatic t_byte_reads();
        dev_word = 16'hA55A;
        do_acc(12'h0C8, 1'b0, 1'b0, 16'h0, 0);
        chk("R2 R3 cmd ofs..00", 32'(m_cmd), 32'h10C8);
        chk("R5 byte read lane0", 32'(m_rdata), 32'h005A);
        do_acc(12'h0C9, 1'b0, 1'b0, 16'h0, 0);
        chk("R3 cmd ofs..01", 32'(m_cmd), 32'h20C9);
        chk("R5 byte read lane1", 32'(m_rdata), 32'h00A5);
        chk("R7 cmd length", 32'(m_cmd_len), 32'(STROBE_CYC));
        chk("R7 gap length", 32'(m_gap), 32'd1);
        chk("R7 data length", 32'(m_data_len), 32'(STROBE_CYC));
        chk("R7 read strobe used", 32'(m_data_rd), 32'd1);
        chk("R9 rsp width", 32'(m_rsp_w), 32'd1);
        do_acc(12'h0CA, 1'b0, 1'b0, 16'h0, 0);
        chk("R3 cmd ofs..10", 32'(m_cmd), 32'h40CA);
        chk("R5 byte read ofs..10", 32'(m_rdata), 32'h005A);
        do_acc(12'hFFF, 1'b0, 1'b0, 16'h0, 0);
        chk("R3 cmd ofs..11", 32'(m_cmd), 32'h8FFF);
        chk("R5 byte read ofs..11", 32'(m_rdata), 32'h00A5);
    endtask

    task automatic t_word_reads();
        dev_word = 16'h1E3C;
        do_acc(12'h010, 1'b1, 1'b0, 16'h0, 0);
        chk("R4 cmd word low", 32'(m_cmd), 32'h3010);
        chk("R5 word read", 32'(m_rdata), 32'h1E3C);
        do_acc(12'h012, 1'b1, 1'b0, 16'h0, 0);
        chk("R4 cmd word high", 32'(m_cmd), 32'hC012);
    endtask

    task automatic t_byte_writes();
        do_acc(12'h041, 1'b0, 1'b1, 16'hFF7E, 0);
        chk("R3 write cmd", 32'(m_cmd), 32'h2041);
        chk("R6 byte write lane1", 32'(m_wdata), 32'h7E00);
        chk("R9 write rdata zero", 32'(m_rdata), 32'h0000);
        chk("R7 no dual strobe", 32'(m_both), 32'd0);
        do_acc(12'h044, 1'b0, 1'b1, 16'hFF33, 0);
        chk("R6 byte write lane0", 32'(m_wdata), 32'h0033);
    endtask

    task automatic t_word_write();
        do_acc(12'h016, 1'b1, 1'b1, 16'hBEEF, 0);
        chk("R4 word write cmd", 32'(m_cmd), 32'hC016);
        chk("R6 word write data", 32'(m_wdata), 32'hBEEF);
        chk("R7 write data length", 32'(m_data_len), 32'(STROBE_CYC));
    endtask

    task automatic t_busy_hold();
        dev_word = 16'h00C3;
        do_acc(12'h020, 1'b0, 1'b0, 16'h0, 3);
        chk("R8 single accept", 32'(m_acc), 32'd1);
        chk("R8 single command", 32'(m_cmd_len), 32'(STROBE_CYC));
        chk("R8 ready after", 32'(req_ready), 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_byte_reads();
        t_word_reads();
        t_byte_writes();
        t_word_write();
        t_busy_hold();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule